// File: doc/BRIEF.md
# Hamming ECC compare and correct

This block checks one 512-byte sector that has been read back from flash against its 24-bit Hamming code. It takes the code stored with the sector and the raw 32-bit value left by the parity calculator after the read. It folds the raw value into the 24-bit stored form and XORs that with the stored code. From the resulting difference it tells the caller one of four things: the sector is clean, a single data bit is wrong (with its byte offset and bit position), only the stored code is damaged, or the sector cannot be repaired. The same packed code is also returned, so the write path can reuse the block to produce the code it stores with a new sector.

The packed code is the bit inverse of the calculator lanes. An erased sector has all-ones data and an all-ones stored code, so it checks clean with no special case. The block applies no correction itself. The buffer that holds the sector flips the reported bit.

Requests travel on a valid-only stream with no back-pressure. The block accepts a request in every cycle that `req_valid` is high. The result appears on the next cycle with a one-cycle `res_valid` pulse. The result fields then hold their value until the next accepted request replaces them, so a consumer that cannot take a result in the strobe cycle can read it later. A producer that needs more than one result in flight must take each result before it issues the next request.

Top module: `hamming_ecc_check`

## Requirements
- R1: `res_code` equals the bitwise inverse of {`req_raw`[27:16], `req_raw`[11:0]}, taken from the accepted request. Raw bits 31:28 and 15:12 have no effect on any output.
- R2: When the difference (`req_stored` XOR packed code) is zero, `res_status` is 0 (clean), and `res_byte` and `res_bit` are 0.
- R3: When difference bits 23:12 XOR difference bits 11:0 is all ones, and the byte offset is below SECTOR_BYTES, `res_status` is 1 (data bit corrected).
- R4: When `res_status` is 1, `res_byte` is difference bits 23:15 and `res_bit` is difference bits 14:12.
- R5: A difference that passes the R3 pattern test but whose byte offset is SECTOR_BYTES or more gives `res_status` 3 (uncorrectable), with `res_byte` and `res_bit` at 0.
- R6: A difference with exactly one bit set gives `res_status` 2 (fault in the stored code only, no flip needed), with `res_byte` and `res_bit` at 0.
- R7: Any other nonzero difference gives `res_status` 3, with `res_byte` and `res_bit` at 0.
- R8: `res_valid` is high in exactly the cycle after each cycle in which `req_valid` is high, and low otherwise. A request is accepted in every cycle that `req_valid` is high.
- R9: While `req_valid` is low, `res_status`, `res_byte`, `res_bit` and `res_code` keep their values, whatever the other request inputs do.
- R10: During reset and until the first request, `res_valid`, `res_status`, `res_byte`, `res_bit` and `res_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; accepted in the same cycle |
| req_stored | input | 24 | Code read from the sector's spare area |
| req_raw | input | 32 | Raw parity calculator value for the sector just read |
| res_valid | output | 1 | One-cycle strobe marking a new result |
| res_status | output | 2 | 0 clean, 1 data bit corrected, 2 code-only fault, 3 uncorrectable |
| res_byte | output | 9 | Byte offset of the bad data bit |
| res_bit | output | 3 | Bit position of the bad data bit within the byte |
| res_code | output | 24 | Packed, inverted code built from `req_raw` |

## Verification
The main function is tried with five kinds of difference, and each kind targets one branch of the classifier. Matching codes are used, including the erased all-ones case and raw values with the ignored lane bits set. Complementary-half differences are used across the whole byte range, which separates a correct location decode from a swapped or shifted one. The bench builds the block with a sector shorter than the 9-bit offset range, so complementary patterns that point past the end of the sector must come out uncorrectable rather than corrected. Single-bit differences are walked over all 24 positions, and random multi-bit differences are also applied. Idle cycles with changing input values sit between requests, which separates a result that is held from one that is recomputed every cycle.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  localparam int HALF_W_DEF   = 12;
  localparam int RAW_W_DEF    = 32;
  localparam int LANE_OFS_DEF = 16;
  localparam int BIT_IDX_W    = 3;

  typedef enum logic [1:0] {
    ST_CLEAN    = 2'd0,
    ST_DATA_FIX = 2'd1,
    ST_CODE_ERR = 2'd2,
    ST_UNCORR   = 2'd3
  } ecc_status_e;

endpackage

// File: rtl/ecc_raw_pack.sv
module ecc_raw_pack #(
  parameter int HALF_W   = ecc_pkg::HALF_W_DEF,
  parameter int RAW_W    = ecc_pkg::RAW_W_DEF,
  parameter int LANE_OFS = ecc_pkg::LANE_OFS_DEF
) (
  input  logic [RAW_W-1:0]    raw_i,
  output logic [2*HALF_W-1:0] code_o
);

  localparam int CODE_W = 2 * HALF_W;

  function automatic logic [RAW_W-1:0] lane_mask();
    logic [RAW_W-1:0] m;
    m = '0;
    for (int i = 0; i < HALF_W; i++) begin
      m[i]            = 1'b1;
      m[LANE_OFS + i] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [RAW_W-1:0] USED_MASK = lane_mask();

  // Low lane feeds the low code half, high lane the high half; both inverted
  // so that an all-zero calculator value maps to the erased all-ones code.
  for (genvar g = 0; g < HALF_W; g++) begin : g_lane
    assign code_o[g]          = ~raw_i[g];
    assign code_o[HALF_W + g] = ~raw_i[LANE_OFS + g];
  end

  logic [RAW_W-1:0] unused_raw_bits;
  assign unused_raw_bits = raw_i & ~USED_MASK;

  logic unused_code_w;
  assign unused_code_w = (CODE_W == 0);

endmodule

// File: rtl/ecc_syndrome_classify.sv
module ecc_syndrome_classify
  import ecc_pkg::*;
#(
  parameter int HALF_W       = ecc_pkg::HALF_W_DEF,
  parameter int SECTOR_BYTES = 512
) (
  input  logic [2*HALF_W-1:0]         stored_i,
  input  logic [2*HALF_W-1:0]         calc_i,
  output ecc_status_e                 status_o,
  output logic [HALF_W-BIT_IDX_W-1:0] byte_o,
  output logic [BIT_IDX_W-1:0]        bit_o
);

  localparam int CODE_W = 2 * HALF_W;
  localparam int BYTE_W = HALF_W - BIT_IDX_W;
  localparam logic [BYTE_W:0] SECT_LIM = SECTOR_BYTES[BYTE_W:0];

  logic [CODE_W-1:0] diff;
  logic [HALF_W-1:0] half_cmp;
  logic              pair_full;
  logic              any_diff;
  logic              one_hot;
  logic [BYTE_W-1:0] loc_byte;
  logic [BIT_IDX_W-1:0] loc_bit;
  logic              loc_in_sector;

  assign diff = stored_i ^ calc_i;

  // Each upper syndrome bit must be the complement of its lower partner.
  for (genvar g = 0; g < HALF_W; g++) begin : g_pair
    assign half_cmp[g] = diff[g] ^ diff[HALF_W + g];
  end

  assign pair_full     = &half_cmp;
  assign any_diff      = |diff;
  assign one_hot       = any_diff && ((diff & (diff - CODE_W'(1))) == '0);
  assign loc_byte      = diff[CODE_W-1 -: BYTE_W];
  assign loc_bit       = diff[HALF_W +: BIT_IDX_W];
  assign loc_in_sector = {1'b0, loc_byte} < SECT_LIM;

  always_comb begin
    status_o = ST_UNCORR;
    byte_o   = '0;
    bit_o    = '0;
    if (!any_diff) begin
      status_o = ST_CLEAN;
    end else if (pair_full) begin
      if (loc_in_sector) begin
        status_o = ST_DATA_FIX;
        byte_o   = loc_byte;
        bit_o    = loc_bit;
      end
    end else if (one_hot) begin
      status_o = ST_CODE_ERR;
    end
  end

endmodule

// File: rtl/ecc_result_reg.sv
module ecc_result_reg
  import ecc_pkg::*;
#(
  parameter int HALF_W = ecc_pkg::HALF_W_DEF
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_i,
  input  ecc_status_e                 status_i,
  input  logic [HALF_W-BIT_IDX_W-1:0] byte_i,
  input  logic [BIT_IDX_W-1:0]        bit_i,
  input  logic [2*HALF_W-1:0]         code_i,
  output logic                        valid_o,
  output ecc_status_e                 status_o,
  output logic [HALF_W-BIT_IDX_W-1:0] byte_o,
  output logic [BIT_IDX_W-1:0]        bit_o,
  output logic [2*HALF_W-1:0]         code_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
    end else begin
      valid_o <= load_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_o <= ST_CLEAN;
      byte_o   <= '0;
      bit_o    <= '0;
      code_o   <= '0;
    end else if (load_i) begin
      status_o <= status_i;
      byte_o   <= byte_i;
      bit_o    <= bit_i;
      code_o   <= code_i;
    end
  end

endmodule

// File: rtl/hamming_ecc_check.sv
module hamming_ecc_check
  import ecc_pkg::*;
#(
  parameter int HALF_W       = ecc_pkg::HALF_W_DEF,
  parameter int RAW_W        = ecc_pkg::RAW_W_DEF,
  parameter int LANE_OFS     = ecc_pkg::LANE_OFS_DEF,
  parameter int SECTOR_BYTES = 512
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [2*HALF_W-1:0]         req_stored,
  input  logic [RAW_W-1:0]            req_raw,
  output logic                        res_valid,
  output logic [1:0]                  res_status,
  output logic [HALF_W-BIT_IDX_W-1:0] res_byte,
  output logic [BIT_IDX_W-1:0]        res_bit,
  output logic [2*HALF_W-1:0]         res_code
);

  localparam int CODE_W = 2 * HALF_W;
  localparam int BYTE_W = HALF_W - BIT_IDX_W;

  logic [CODE_W-1:0]    calc_code;
  ecc_status_e          cls_status;
  logic [BYTE_W-1:0]    cls_byte;
  logic [BIT_IDX_W-1:0] cls_bit;
  ecc_status_e          held_status;

  ecc_raw_pack #(
    .HALF_W  (HALF_W),
    .RAW_W   (RAW_W),
    .LANE_OFS(LANE_OFS)
  ) u_pack (
    .raw_i (req_raw),
    .code_o(calc_code)
  );

  ecc_syndrome_classify #(
    .HALF_W      (HALF_W),
    .SECTOR_BYTES(SECTOR_BYTES)
  ) u_classify (
    .stored_i(req_stored),
    .calc_i  (calc_code),
    .status_o(cls_status),
    .byte_o  (cls_byte),
    .bit_o   (cls_bit)
  );

  ecc_result_reg #(
    .HALF_W(HALF_W)
  ) u_result (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (req_valid),
    .status_i(cls_status),
    .byte_i  (cls_byte),
    .bit_i   (cls_bit),
    .code_i  (calc_code),
    .valid_o (res_valid),
    .status_o(held_status),
    .byte_o  (res_byte),
    .bit_o   (res_bit),
    .code_o  (res_code)
  );

  assign res_status = held_status;

endmodule

// File: rtl/hamming_ecc_check_sva.sv
module hamming_ecc_check_sva #(
  parameter int HALF_W       = 12,
  parameter int RAW_W        = 32,
  parameter int LANE_OFS     = 16,
  parameter int SECTOR_BYTES = 512
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic [2*HALF_W-1:0]  req_stored,
  input logic [RAW_W-1:0]     req_raw,
  input logic                 res_valid,
  input logic [1:0]           res_status,
  input logic [HALF_W-4:0]    res_byte,
  input logic [2:0]           res_bit,
  input logic [2*HALF_W-1:0]  res_code
);

  logic [2*HALF_W-1:0] expect_code;
  logic [2*HALF_W-1:0] diff_chk;
  logic                pair_chk;
  logic                unused_raw_par;

  assign expect_code    = ~{req_raw[LANE_OFS +: HALF_W], req_raw[HALF_W-1:0]};
  assign diff_chk       = req_stored ^ expect_code;
  assign pair_chk       = &(diff_chk[2*HALF_W-1:HALF_W] ^ diff_chk[HALF_W-1:0]);
  assign unused_raw_par = ^req_raw;

  // R1
  p_pack_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_code == $past(expect_code));

  // R2
  p_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && diff_chk == '0) |=> (res_status == 2'd0 && res_byte == '0 && res_bit == '0));

  // R3 and R5: a complementary pattern is never clean nor a code-only fault
  p_pair_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pair_chk) |=> (res_status == 2'd1 || res_status == 2'd3));

  // R5
  p_in_sector_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status == 2'd1) |-> int'(res_byte) < SECTOR_BYTES);

  // R6
  p_code_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $countones(diff_chk) == 1) |=> (res_status == 2'd2 && res_byte == '0 && res_bit == '0));

  // R7
  p_no_loc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status != 2'd1) |-> (res_byte == '0 && res_bit == '0));

  // R8
  p_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  p_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);

  // R9
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(res_status) && $stable(res_byte) && $stable(res_bit) && $stable(res_code)));

endmodule

bind hamming_ecc_check hamming_ecc_check_sva #(
  .HALF_W      (HALF_W),
  .RAW_W       (RAW_W),
  .LANE_OFS    (LANE_OFS),
  .SECTOR_BYTES(SECTOR_BYTES)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_stored(req_stored),
  .req_raw   (req_raw),
  .res_valid (res_valid),
  .res_status(res_status),
  .res_byte  (res_byte),
  .res_bit   (res_bit),
  .res_code  (res_code)
);

// File: tb/tb_hamming_ecc_check.sv
module tb_hamming_ecc_check;

  localparam int CLK_PERIOD = 10;
  localparam int SECT       = 384;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [23:0] req_stored = '0;
  logic [31:0] req_raw = '0;
  logic        res_valid;
  logic [1:0]  res_status;
  logic [8:0]  res_byte;
  logic [2:0]  res_bit;
  logic [23:0] res_code;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // Reference state: what the outputs must show after the coming edge.
  logic        exp_valid = 0;
  int unsigned exp_status = 0;
  int unsigned exp_byte = 0;
  int unsigned exp_bit = 0;
  int unsigned exp_code = 0;
  string       exp_tag = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  hamming_ecc_check #(.SECTOR_BYTES(SECT)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_stored(req_stored), .req_raw(req_raw),
    .res_valid(res_valid), .res_status(res_status),
    .res_byte(res_byte), .res_bit(res_bit), .res_code(res_code)
  );

  task automatic check(string tag, string what, int unsigned act, int unsigned exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int unsigned code_of(int unsigned raw);
    return ((raw & 32'h0000_0fff) | ((raw >> 4) & 32'h00ff_f000)) ^ 32'h00ff_ffff;
  endfunction

  function automatic int unsigned data_diff(int unsigned byte_off, int unsigned bit_pos);
    int unsigned u = (byte_off << 3) | bit_pos;
    return (u << 12) | (~u & 32'hfff);
  endfunction

  task automatic compare_now();
    check("R8", "res_valid", res_valid, exp_valid);
    check({exp_tag, " R8"}, "res_status", res_status, exp_status);
    check({exp_tag, " R4"}, "res_byte", res_byte, exp_byte);
    check({exp_tag, " R4"}, "res_bit", res_bit, exp_bit);
    check({exp_tag, " R1"}, "res_code", res_code, exp_code);
  endtask

  task automatic model(int unsigned st, int unsigned raw);
    int unsigned code = code_of(raw);
    int unsigned d = (st ^ code) & 32'hff_ffff;
    exp_valid = 1;
    exp_code = code;
    exp_byte = 0;
    exp_bit = 0;
    if (d == 0) begin
      exp_status = 0; exp_tag = "R2";
    end else if ((((d >> 12) ^ d) & 32'hfff) == 32'hfff) begin
      if ((d >> 15) < SECT) begin
        exp_status = 1; exp_tag = "R3";
        exp_byte = d >> 15;
        exp_bit = (d >> 12) & 7;
      end else begin
        exp_status = 3; exp_tag = "R5";
      end
    end else if ((d & (d - 1)) == 0) begin
      exp_status = 2; exp_tag = "R6";
    end else begin
      exp_status = 3; exp_tag = "R7";
    end
  endtask

  task automatic step(bit v, int unsigned st, int unsigned raw);
    @(negedge clk);
    compare_now();
    req_valid = v;
    req_stored = st[23:0];
    req_raw = raw;
    if (v) model(st, raw);
    else begin
      exp_valid = 0;
      if (exp_tag.len() < 3 || exp_tag.substr(0, 2) != "R9 ") exp_tag = {"R9 ", exp_tag};
    end
  endtask

  task automatic idle_noise(int n);
    for (int i = 0; i < n; i++) step(0, $urandom, $urandom);
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    int bl[6] = '{0, 1, 77, 255, 300, 383};
    int ol[4] = '{384, 385, 450, 511};
    int unsigned raw;
    int unsigned d;

    // R10: reset values while reset is held
    repeat (3) @(negedge clk);
    check("R10", "res_valid", res_valid, 0);
    check("R10", "res_status", res_status, 0);
    check("R10", "res_byte", res_byte, 0);
    check("R10", "res_bit", res_bit, 0);
    check("R10", "res_code", res_code, 0);
    rst_n = 1'b1;
    step(0, $urandom, $urandom);   // R10 state still held before any request

    // R2 clean codes, including the erased sector
    for (int i = 0; i < 6; i++) begin
      raw = $urandom;
      step(1, code_of(raw), raw);
    end
    step(1, 24'hff_ffff, 32'h0);

    // R1 ignored raw bits: stored code built without them
    for (int i = 0; i < 4; i++) begin
      raw = $urandom | 32'hf000_f000;
      step(1, code_of(raw & 32'h0fff_0fff), raw);
    end
    idle_noise(3);

    // R3 / R4 single data bit errors across the sector
    foreach (bl[i]) begin
      for (int k = 0; k < 8; k++) begin
        raw = $urandom;
        step(1, code_of(raw) ^ data_diff(bl[i], k), raw);
      end
      idle_noise(1);
    end

    // R5 location past the end of the sector
    foreach (ol[i]) begin
      raw = $urandom;
      step(1, code_of(raw) ^ data_diff(ol[i], 5), raw);
    end
    idle_noise(2);

    // R6 single fault in the stored code
    for (int n = 0; n < 24; n++) begin
      raw = $urandom;
      step(1, code_of(raw) ^ (32'h1 << n), raw);
    end

    // R7 two-bit and random multi-bit differences
    for (int i = 0; i < 24; i++) begin
      raw = $urandom;
      d = (32'h1 << i) | (32'h1 << ((i + 7) % 24));
      step(1, code_of(raw) ^ d, raw);
    end
    for (int i = 0; i < 20; i++) begin
      raw = $urandom;
      step(1, code_of(raw) ^ ($urandom | 32'h3), raw);
    end

    // R9 hold over a longer idle stretch
    idle_noise(5);
    step(0, 0, 0);

    finished = 1;
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      report();
      $finish;
    end
  end

endmodule